// File: doc/BRIEF.md
# Runahead Mode Controller

This block sits beside a small in-order pipeline model and decides when that pipeline may keep running past a load that missed in the last-level cache. Each cycle the pipeline presents at most one decoded micro-op. The micro-op carries its program counter, two source register indices, one destination index, an immediate, the load data for a hit, and a flag that marks a last-level miss. The block holds the register file. It executes ALU adds, loads and stores. It reports every register write on a writeback port and every architectural store on a store port.

When a load in normal mode misses, the block copies the register file into a checkpoint and switches to runahead mode. In runahead mode, micro-ops keep executing so that the addresses they compute reach memory early, as prefetches. Any value that depends on a missing load carries an invalid flag. That flag moves from sources to destinations, and it suppresses prefetches whose address cannot be known. Stores in this mode never leave the block. When the original miss returns, the checkpoint is restored, every invalid flag is cleared, and the block emits a resume pulse carrying the PC of the missing load. The pipeline then refetches from that PC.

Top module: `ra_ctrl`

## Requirements
- R1: A LOAD (op code 1; 0 = ALU add, 2 = STORE, 3 = NOP) accepted in normal mode with `uop_miss` high raises `ra_active` on the next cycle, and its writeback reports the destination with `wb_inv` = 1. The miss flag on a non-load, and a load without the flag, never start runahead.
- R2: At entry the register values are saved. On exit they are restored and all invalid flags are cleared, so a later read returns exactly the values held before the missing load.
- R3: A runahead LOAD whose address register (source A) is valid issues `pf_valid` one cycle later, with `pf_addr` = value(A) + `uop_imm`. A normal-mode load issues no prefetch.
- R4: An ALU add writes value(A) + value(B) to its destination. The destination is invalid if either source is invalid; a result from two valid sources clears the destination's invalid flag.
- R5: A miss return while in runahead drops `ra_active` and pulses `resume_valid` for one cycle, with `resume_pc` equal to the PC of the load that started runahead. A micro-op presented in that same cycle is discarded.
- R6: A runahead LOAD whose address register is invalid issues no prefetch and writes its destination as invalid.
- R7: A STORE in normal mode drives `st_valid` with `st_addr` = value(A) + `uop_imm` and `st_data` = value(B). A STORE in runahead mode produces no store output and changes no register.
- R8: A load that misses during runahead does not take a new checkpoint and does not change the resume PC. It prefetches if its address is valid and marks its destination invalid.
- R9: Runahead lasts until the miss return, however many micro-ops run in it. A miss return in normal mode has no effect.
- R10: After reset, all outputs are low, the block is in normal mode, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid | input | 1 | Micro-op present this cycle |
| uop_op | input | 2 | 0 ALU add, 1 LOAD, 2 STORE, 3 NOP |
| uop_pc | input | PCW | Program counter of the micro-op |
| uop_src_a | input | IW | Source A index (address base for memory ops) |
| uop_src_b | input | IW | Source B index (store data) |
| uop_dst | input | IW | Destination index |
| uop_imm | input | DW | Address offset |
| uop_ldata | input | DW | Load data on a hit |
| uop_miss | input | 1 | Load missed in the last-level cache |
| miss_ret_valid | input | 1 | Data of the original miss has returned |
| ra_active | output | 1 | Runahead mode |
| resume_valid | output | 1 | Restart pulse |
| resume_pc | output | PCW | PC at which to restart |
| wb_valid | output | 1 | Register write performed |
| wb_dst | output | IW | Written register |
| wb_data | output | DW | Written value |
| wb_inv | output | 1 | Written value is invalid |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | DW | Prefetch address |
| st_valid | output | 1 | Architectural store |
| st_addr | output | DW | Store address |
| st_data | output | DW | Store data |

## Verification
A corrupted invalid flag appears one cycle after a dependent micro-op, either as a wrong `wb_inv` or as a prefetch that is missing or should not be there. A bad checkpoint stays hidden until the exit. It appears on the first writeback or store after `resume_valid` that reads a restored register. The bench therefore reads every register in normal mode after each exit, and it mixes valid and invalid sources across the runahead interval.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic [1:0] {
        OP_ALU   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_NOP   = 2'd3
    } op_e;
endpackage

// File: rtl/ra_regfile.sv
module ra_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_a_idx,
    input  logic [IW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_a_val,
    output logic          rd_a_inv,
    output logic [DW-1:0] rd_b_val,
    output logic          rd_b_inv,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic          wr_inv,
    input  logic          save,
    input  logic          restore
);
    logic [DW-1:0] vals [NREG];
    logic [NREG-1:0] invs;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] v_q, v_d, c_q, c_d;
        logic          f_q, f_d;

        always_comb begin
            v_d = v_q;
            f_d = f_q;
            c_d = c_q;
            if (save) c_d = v_q;
            if (restore) begin
                v_d = c_q;
                f_d = 1'b0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                v_d = wr_val;
                f_d = wr_inv;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= '0;
                f_q <= 1'b0;
                c_q <= '0;
            end else begin
                v_q <= v_d;
                f_q <= f_d;
                c_q <= c_d;
            end
        end

        assign vals[i] = v_q;
        assign invs[i] = f_q;
    end

    assign rd_a_val = vals[rd_a_idx];
    assign rd_a_inv = invs[rd_a_idx];
    assign rd_b_val = vals[rd_b_idx];
    assign rd_b_inv = invs[rd_b_idx];
endmodule

// File: rtl/ra_exec.sv
module ra_exec
    import ra_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic          active,
    input  logic          miss,
    input  logic [DW-1:0] a_val,
    input  logic          a_inv,
    input  logic [DW-1:0] b_val,
    input  logic          b_inv,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] ldata,
    output logic          wr_en,
    output logic [DW-1:0] wr_val,
    output logic          wr_inv,
    output logic          pf_req,
    output logic          st_req,
    output logic          enter,
    output logic [DW-1:0] addr
);
    always_comb begin
        wr_en  = 1'b0;
        wr_val = '0;
        wr_inv = 1'b0;
        pf_req = 1'b0;
        st_req = 1'b0;
        enter  = 1'b0;
        addr   = a_val + imm;
        unique case (op)
            OP_ALU: begin
                wr_en  = 1'b1;
                wr_val = a_val + b_val;
                wr_inv = a_inv | b_inv;
            end
            OP_LOAD: begin
                wr_en  = 1'b1;
                wr_val = ldata;
                if (active) begin
                    wr_inv = a_inv | miss;
                    pf_req = !a_inv;
                end else begin
                    wr_inv = miss;
                    enter  = miss;
                end
            end
            OP_STORE: st_req = !active;
            default: ;
        endcase
    end
endmodule

// File: rtl/ra_ctrl.sv
module ra_ctrl
    import ra_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int PCW  = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           uop_valid,
    input  logic [1:0]     uop_op,
    input  logic [PCW-1:0] uop_pc,
    input  logic [IW-1:0]  uop_src_a,
    input  logic [IW-1:0]  uop_src_b,
    input  logic [IW-1:0]  uop_dst,
    input  logic [DW-1:0]  uop_imm,
    input  logic [DW-1:0]  uop_ldata,
    input  logic           uop_miss,
    input  logic           miss_ret_valid,
    output logic           ra_active,
    output logic           resume_valid,
    output logic [PCW-1:0] resume_pc,
    output logic           wb_valid,
    output logic [IW-1:0]  wb_dst,
    output logic [DW-1:0]  wb_data,
    output logic           wb_inv,
    output logic           pf_valid,
    output logic [DW-1:0]  pf_addr,
    output logic           st_valid,
    output logic [DW-1:0]  st_addr,
    output logic [DW-1:0]  st_data
);
    typedef struct packed {
        logic           active;
        logic [PCW-1:0] miss_pc;
        logic           res_v;
        logic           wb_v;
        logic [IW-1:0]  wb_d;
        logic [DW-1:0]  wb_x;
        logic           wb_i;
        logic           pf_v;
        logic [DW-1:0]  pf_a;
        logic           st_v;
        logic [DW-1:0]  st_a;
        logic [DW-1:0]  st_x;
    } state_t;

    state_t s_q, s_d;

    logic [DW-1:0] a_val, b_val, x_val, x_addr;
    logic          a_inv, b_inv, x_inv;
    logic          x_wr, x_pf, x_st, x_enter;
    logic          leaving, go;

    assign leaving = s_q.active && miss_ret_valid;
    assign go      = uop_valid && !leaving;

    ra_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (uop_src_a),
        .rd_b_idx (uop_src_b),
        .rd_a_val (a_val),
        .rd_a_inv (a_inv),
        .rd_b_val (b_val),
        .rd_b_inv (b_inv),
        .wr_en    (go && x_wr),
        .wr_idx   (uop_dst),
        .wr_val   (x_val),
        .wr_inv   (x_inv),
        .save     (go && x_enter),
        .restore  (leaving)
    );

    ra_exec #(.DW(DW)) u_ex (
        .op     (op_e'(uop_op)),
        .active (s_q.active),
        .miss   (uop_miss),
        .a_val  (a_val),
        .a_inv  (a_inv),
        .b_val  (b_val),
        .b_inv  (b_inv),
        .imm    (uop_imm),
        .ldata  (uop_ldata),
        .wr_en  (x_wr),
        .wr_val (x_val),
        .wr_inv (x_inv),
        .pf_req (x_pf),
        .st_req (x_st),
        .enter  (x_enter),
        .addr   (x_addr)
    );

    always_comb begin
        s_d       = s_q;
        s_d.res_v = 1'b0;
        s_d.wb_v  = 1'b0;
        s_d.pf_v  = 1'b0;
        s_d.st_v  = 1'b0;
        if (leaving) begin
            s_d.active = 1'b0;
            s_d.res_v  = 1'b1;
        end else if (go) begin
            if (x_enter) begin
                s_d.active  = 1'b1;
                s_d.miss_pc = uop_pc;
            end
            if (x_wr) begin
                s_d.wb_v = 1'b1;
                s_d.wb_d = uop_dst;
                s_d.wb_x = x_val;
                s_d.wb_i = x_inv;
            end
            if (x_pf) begin
                s_d.pf_v = 1'b1;
                s_d.pf_a = x_addr;
            end
            if (x_st) begin
                s_d.st_v = 1'b1;
                s_d.st_a = x_addr;
                s_d.st_x = b_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ra_active    = s_q.active;
    assign resume_valid = s_q.res_v;
    assign resume_pc    = s_q.miss_pc;
    assign wb_valid     = s_q.wb_v;
    assign wb_dst       = s_q.wb_d;
    assign wb_data      = s_q.wb_x;
    assign wb_inv       = s_q.wb_i;
    assign pf_valid     = s_q.pf_v;
    assign pf_addr      = s_q.pf_a;
    assign st_valid     = s_q.st_v;
    assign st_addr      = s_q.st_a;
    assign st_data      = s_q.st_x;
endmodule

// File: rtl/ra_ctrl_chk.sv
module ra_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uop_valid,
    input logic [1:0] uop_op,
    input logic       uop_miss,
    input logic       miss_ret_valid,
    input logic       ra_active,
    input logic       resume_valid,
    input logic       pf_valid,
    input logic       st_valid
);
    AST_ENTRY_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ra_active) |-> $past(uop_valid && uop_op == 2'd1 && uop_miss)); // R1
    AST_PF_ONLY_RUNAHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(ra_active)); // R3
    AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ra_active && miss_ret_valid |=> resume_valid && !ra_active); // R5
    AST_NO_STORE_RUNAHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ra_active && uop_valid && uop_op == 2'd2 |=> !st_valid); // R7
    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ra_active && !miss_ret_valid |=> ra_active); // R9
    AST_NO_STRAY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_active |=> !resume_valid); // R9
endmodule

bind ra_ctrl ra_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .uop_valid      (uop_valid),
    .uop_op         (uop_op),
    .uop_miss       (uop_miss),
    .miss_ret_valid (miss_ret_valid),
    .ra_active      (ra_active),
    .resume_valid   (resume_valid),
    .pf_valid       (pf_valid),
    .st_valid       (st_valid)
);

// File: tb/ra_ctrl_tb.sv
`timescale 1ns/1ps
module ra_ctrl_tb;
    localparam int NREG = 8, DW = 16, PCW = 16, IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           uop_valid = 0, uop_miss = 0, miss_ret_valid = 0;
    logic [1:0]     uop_op = 0;
    logic [PCW-1:0] uop_pc = 0;
    logic [IW-1:0]  uop_src_a = 0, uop_src_b = 0, uop_dst = 0;
    logic [DW-1:0]  uop_imm = 0, uop_ldata = 0;
    logic           ra_active, resume_valid, wb_valid, wb_inv, pf_valid, st_valid;
    logic [PCW-1:0] resume_pc;
    logic [IW-1:0]  wb_dst;
    logic [DW-1:0]  wb_data, pf_addr, st_addr, st_data;

    ra_ctrl #(.NREG(NREG), .DW(DW), .PCW(PCW)) u_dut (.*);

    int tests = 0, fails = 0, cycles = 0;
    always @(posedge clk) cycles <= cycles + 1;

    // reference model state
    int  m_reg [NREG];
    bit  m_inv [NREG];
    int  m_ckp [NREG];
    bit  m_act;
    int  m_rpc;
    bit  e_res, e_wb, e_wbi, e_pf, e_st;
    int  e_wbd, e_wbx, e_pfa, e_sta, e_stx;

    task automatic report(string tag, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic compare(string tag);
        int bad = fails;
        tests++;
        if (ra_active !== m_act) report(tag, "ra_active", ra_active, m_act);
        if (resume_valid !== e_res) report(tag, "resume_valid", resume_valid, e_res);
        if (e_res && resume_pc !== PCW'(m_rpc)) report(tag, "resume_pc", resume_pc, m_rpc);
        if (wb_valid !== e_wb) report(tag, "wb_valid", wb_valid, e_wb);
        if (e_wb) begin
            if (wb_dst !== IW'(e_wbd)) report(tag, "wb_dst", wb_dst, e_wbd);
            if (wb_inv !== e_wbi) report(tag, "wb_inv", wb_inv, e_wbi);
            if (!e_wbi && wb_data !== DW'(e_wbx)) report(tag, "wb_data", wb_data, e_wbx);
        end
        if (pf_valid !== e_pf) report(tag, "pf_valid", pf_valid, e_pf);
        if (e_pf && pf_addr !== DW'(e_pfa)) report(tag, "pf_addr", pf_addr, e_pfa);
        if (st_valid !== e_st) report(tag, "st_valid", st_valid, e_st);
        if (e_st && (st_addr !== DW'(e_sta) || st_data !== DW'(e_stx)))
            report(tag, "st_addr/data", {st_addr, st_data}, (e_sta << 16) | e_stx);
        if (fails > bad + 1) fails = bad + 1;
    endtask

    task automatic cyc(string tag, bit v, int op, int a, int b, int d,
                       int imm, int ld, int pc, bit miss, bit ret);
        uop_valid = v; uop_op = 2'(op); uop_src_a = IW'(a); uop_src_b = IW'(b);
        uop_dst = IW'(d); uop_imm = DW'(imm); uop_ldata = DW'(ld); uop_pc = PCW'(pc);
        uop_miss = miss; miss_ret_valid = ret;
        e_res = 0; e_wb = 0; e_pf = 0; e_st = 0;
        if (m_act && ret) begin
            for (int i = 0; i < NREG; i++) begin m_reg[i] = m_ckp[i]; m_inv[i] = 0; end
            m_act = 0; e_res = 1;
        end else if (v) begin
            int addr = (m_reg[a] + imm) & 16'hFFFF;
            if (op == 0) begin
                e_wb = 1; e_wbd = d; e_wbx = (m_reg[a] + m_reg[b]) & 16'hFFFF;
                e_wbi = m_inv[a] | m_inv[b];
            end else if (op == 1) begin
                e_wb = 1; e_wbd = d; e_wbx = ld & 16'hFFFF;
                if (m_act) begin
                    e_wbi = m_inv[a] | miss;
                    e_pf = !m_inv[a]; e_pfa = addr;
                end else begin
                    e_wbi = miss;
                    if (miss) begin
                        for (int i = 0; i < NREG; i++) m_ckp[i] = m_reg[i];
                        m_act = 1; m_rpc = pc;
                    end
                end
            end else if (op == 2 && !m_act) begin
                e_st = 1; e_sta = addr; e_stx = m_reg[b];
            end
            if (e_wb) begin m_reg[d] = e_wbx; m_inv[d] = e_wbi; end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    // shorthand helpers
    task automatic alu(string tag, int a, int b, int d);
        cyc(tag, 1, 0, a, b, d, 0, 0, 0, 0, 0);
    endtask
    task automatic load(string tag, int a, int imm, int d, int ld, int pc, bit miss);
        cyc(tag, 1, 1, a, 0, d, imm, ld, pc, miss, 0);
    endtask
    task automatic store(string tag, int a, int b, int imm);
        cyc(tag, 1, 2, a, b, 0, imm, 0, 0, 0, 0);
    endtask
    task automatic readall(string tag);
        for (int i = 0; i < NREG; i++) alu(tag, i, 0, 0);
        for (int i = 0; i < NREG; i++) store(tag, 0, i, i);
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin m_reg[i] = 0; m_inv[i] = 0; m_ckp[i] = 0; end
        m_act = 0; m_rpc = 0;
        e_res = 0; e_wb = 0; e_pf = 0; e_st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R10 reset outputs");
        readall("R10 reset registers");

        // normal mode
        load("R3 normal hit, no prefetch", 0, 16'h100, 1, 16'h0010, 16'h10, 0);
        load("R4 normal load", 0, 16'h104, 2, 16'h0003, 16'h14, 0);
        alu("R4 normal add", 1, 2, 3);
        store("R7 normal store", 1, 2, 4);
        cyc("R9 return outside runahead", 0, 3, 0, 0, 0, 0, 0, 0, 0, 1);
        cyc("R1 miss flag on ALU ignored", 1, 0, 1, 1, 5, 0, 0, 16'h30, 1, 0);
        cyc("R1 NOP", 1, 3, 0, 0, 0, 0, 0, 0, 1, 0);

        // first runahead episode
        load("R1 entering miss", 1, 8, 4, 16'hBEEF, 16'h40, 1);
        alu("R4 inv propagates", 4, 1, 5);
        load("R3 runahead prefetch", 1, 16'h20, 6, 16'h0777, 16'h44, 0);
        load("R6 inv address", 5, 0, 7, 16'h1234, 16'h48, 0);
        store("R7 runahead store held", 1, 2, 0);
        alu("R4 valid result clears inv", 1, 2, 4);
        alu("R4 cleared reg reads valid", 4, 4, 5);
        load("R8 second miss", 1, 16'h40, 2, 0, 16'h60, 1);
        alu("R8 second miss dst inv", 2, 1, 3);
        load("R8 miss on inv addr", 2, 4, 0, 0, 16'h64, 1);
        for (int k = 0; k < 300; k++) begin
            if (k % 3 == 0) alu("R9 long runahead", k % 8, (k + 1) % 8, (k + 2) % 8);
            else if (k % 3 == 1) load("R9 long runahead", k % 8, k, (k + 3) % 8, k, k, k % 5 == 0);
            else store("R9 long runahead", k % 8, 1, k);
        end
        cyc("R5 exit drops concurrent uop", 1, 0, 1, 1, 1, 0, 0, 0, 0, 1);
        cyc("R5 resume is one pulse", 0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        readall("R2 restored registers");

        // second episode: miss data returns right away
        load("R1 second entry", 3, 0, 6, 0, 16'h80, 1);
        cyc("R5 immediate return", 0, 3, 0, 0, 0, 0, 0, 0, 0, 1);
        readall("R2 restore after short episode");

        // third episode: build values, enter, overwrite all, exit
        for (int i = 1; i < NREG; i++) load("R4 seed", 0, 0, i, i * 16'h111, 16'h90 + i, 0);
        load("R1 third entry", 7, 2, 0, 0, 16'hA0, 1);
        for (int i = 0; i < NREG; i++) load("R8 overwrite in runahead", 0, i, i, 16'hF0F0, 16'hA4, i == 3);
        cyc("R5 third exit", 0, 3, 0, 0, 0, 0, 0, 0, 0, 1);
        readall("R2 third restore");
        store("R7 normal store after exit", 7, 6, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule